// File: doc/BRIEF.md
# Multiword DMA Host Transfer Engine

This block is the host end of a 16-bit multiword DMA link to a storage drive. Once armed by a start pulse with a direction, a word count and a timing mode, it waits for the drive's request line. It raises its acknowledge and then issues one read or write strobe per word. It keeps going until the count is used up, the drive withdraws its request, or the host-side word stream cannot keep up. It then drops acknowledge and reports how many words moved.

The strobe high time and the strobe-to-strobe period come from a per-mode table written in nanoseconds. They are turned into clock cycles from a clock period parameter. The drive's request passes through a two-flop synchronizer. After acknowledge rises, the request is treated as still asserted for the drive's worst-case turnaround time plus the synchronizer latency. On the host side, words to write arrive on a valid/ready stream and words read leave on another. The bus side has a data output, a data input and an output enable for the shared bus.

Top module: `mdma_host`

## Requirements
- R1: After reset, `dev_ack`, `rd_strobe`, `wr_strobe`, `dd_oe`, `busy`, `done`, `rd_valid` and `wr_ready` are all low.
- R2: `dev_ack` rises only after the synchronized `dev_req` has been seen high. It stays low for as long as `dev_req` is low, even with a burst armed (`busy` high). The first strobe rises one cycle after `dev_ack`, and a strobe is high only while `dev_ack` is high.
- R3: Each strobe stays high for ceil(T/CLK_NS) cycles, where T is 480, 240 or 120 ns for `dma_mode` 0, 1 or 2. At CLK_NS=5 that is 96, 48 or 24 cycles.
- R4: Within a burst, successive strobe rising edges are ceil(P/CLK_NS) cycles apart, where P is 960, 480 or 240 ns for modes 0, 1 and 2. At CLK_NS=5 that is 192, 96 or 48 cycles.
- R5: In a write burst, each strobe carries the next accepted stream word on `dd_out`, in order, with `dd_oe` high. `dd_oe` is high only while `dev_ack` is high.
- R6: In a read burst, `dd_in` is sampled on the last high cycle of each strobe. The words leave on `rd_data`/`rd_valid` in bus order, each held until taken with `rd_ready`.
- R7: A burst that is not cut short moves exactly `word_count` words. `done` is then high for one cycle, with `done_words` equal to the number of words moved.
- R8: A burst ends after the current word if the synchronized request is low when the word period ends. The request is disregarded for ceil(tC/CLK_NS)+2 cycles after `dev_ack` rises, where tC is 200, 100 or 80 ns by mode.
- R9: A burst ends after the current word if the host stream cannot take part at the word boundary. For writes this means `wr_valid` is low. For reads it means a word is still waiting in `rd_data` with `rd_ready` low.
- R10: `dma_mode` is encoded 0, 1 and 2. The value 3 uses mode 2 timing. The mode is latched at start.
- R11: A start pulse while `busy` is high is ignored. The running burst keeps its count, and no second burst follows.
- R12: A start with `word_count` 0 gives a `done` pulse with `done_words` 0 and never raises `dev_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm a burst (sampled while idle) |
| dir_write | input | 1 | 1 = host to drive, 0 = drive to host |
| word_count | input | CNT_W | Words to move |
| dma_mode | input | 2 | Timing mode 0..2 (3 acts as 2) |
| busy | output | 1 | Burst armed or running |
| done | output | 1 | One-cycle end-of-burst pulse |
| done_words | output | CNT_W | Words moved, valid with `done` |
| wr_data | input | DW | Stream word to write |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Engine takes `wr_data` this cycle |
| rd_data | output | DW | Word read from the drive |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_ready | input | 1 | Host takes `rd_data` |
| dev_req | input | 1 | Drive request, asynchronous |
| dev_ack | output | 1 | Host acknowledge |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| dd_in | input | DW | Bus data from the drive |
| dd_out | output | DW | Bus data to the drive |
| dd_oe | output | 1 | Host drives the data bus |

## Verification
The assertions assume that the host stream follows valid/ready rules: `wr_valid` and `wr_data` stay put until the word is taken. They also assume that a new start is only meaningful while idle. The bench changes stream inputs only after a clock edge, from a queue, and never withdraws a valid word. The drive model changes `dev_req` only on falling clock edges, and it loads `dd_in` on each read strobe rise, well before the sampling cycle. The single overlapping start in the R11 case is deliberate, and it only tests that such a start is dropped.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_ACK,
    S_STB,
    S_REC,
    S_FIN
  } mdma_state_e;

  // ceil(ns / clk_ns)
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // full word period per mode
  function automatic int cycle_ns(input logic [1:0] m);
    case (m)
      2'd0:    return 960;
      2'd1:    return 480;
      default: return 240;
    endcase
  endfunction

  // strobe high time per mode
  function automatic int strobe_ns(input logic [1:0] m);
    case (m)
      2'd0:    return 480;
      2'd1:    return 240;
      default: return 120;
    endcase
  endfunction

  // drive turnaround after acknowledge per mode
  function automatic int turn_ns(input logic [1:0] m);
    case (m)
      2'd0:    return 200;
      2'd1:    return 100;
      default: return 80;
    endcase
  endfunction

endpackage

// File: rtl/mdma_sync.sv
module mdma_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/mdma_timing.sv
module mdma_timing #(
  parameter int CLK_NS      = 5,
  parameter int TMR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic [1:0]       mode_q,
  output logic [TMR_W-1:0] stb_len,
  output logic [TMR_W-1:0] rec_len,
  output logic [TMR_W-1:0] win_len
);
  import mdma_pkg::*;

  always_comb begin
    stb_len = TMR_W'(ns2cyc(strobe_ns(mode_q), CLK_NS));
    rec_len = TMR_W'(ns2cyc(cycle_ns(mode_q), CLK_NS)
                     - ns2cyc(strobe_ns(mode_q), CLK_NS));
    win_len = TMR_W'(ns2cyc(turn_ns(mode_q), CLK_NS) + SYNC_STAGES);
  end
endmodule

// File: rtl/mdma_seq.sv
module mdma_seq #(
  parameter int CNT_W = 16,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_write,
  input  logic [CNT_W-1:0] word_count,
  input  logic [1:0]       dma_mode,
  input  logic [TMR_W-1:0] stb_len,
  input  logic [TMR_W-1:0] rec_len,
  input  logic [TMR_W-1:0] win_len,
  input  logic             req_s,
  input  logic             wr_valid,
  input  logic             rd_valid,
  input  logic             rd_ready,
  output logic [1:0]       mode_q,
  output logic             dir_q,
  output logic             dev_ack,
  output logic             stb_q,
  output logic             dd_oe,
  output logic             wr_ready,
  output logic             rd_capture,
  output logic             word_end,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] done_words
);
  import mdma_pkg::*;

  mdma_state_e      st, nxt;
  logic [CNT_W-1:0] left_q, xfer_q;
  logic [TMR_W-1:0] tmr_q, win_q;
  logic             go_ok, more, dec_pt, stb_end, arm_go;

  // host stream can take part in one more word
  assign go_ok   = dir_q ? wr_valid : (!rd_valid || rd_ready);
  assign stb_end = (st == S_STB) && (tmr_q == '0);
  assign dec_pt  = (st == S_REC) && (tmr_q == '0);
  // request counts as high while the turnaround window is open
  assign more    = (left_q != '0) && (req_s || (win_q != '0)) && go_ok;
  assign arm_go  = (st == S_ARM) && req_s && go_ok;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (start) nxt = (word_count == '0) ? S_FIN : S_ARM;
      S_ARM:  if (arm_go) nxt = S_ACK;
      S_ACK:  nxt = S_STB;
      S_STB:  if (stb_end) nxt = S_REC;
      S_REC:  if (dec_pt) nxt = more ? S_STB : S_FIN;
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dir_q   <= 1'b0;
      mode_q  <= 2'd0;
      left_q  <= '0;
      xfer_q  <= '0;
      tmr_q   <= '0;
      win_q   <= '0;
      dev_ack <= 1'b0;
      stb_q   <= 1'b0;
      dd_oe   <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start) begin
        dir_q  <= dir_write;
        mode_q <= dma_mode;
        left_q <= word_count;
        xfer_q <= '0;
      end
      if (arm_go) win_q <= win_len;
      else if (win_q != '0) win_q <= win_q - TMR_W'(1);

      if (nxt == S_STB && st != S_STB) begin
        tmr_q <= stb_len - TMR_W'(1);
      end else if (stb_end) begin
        tmr_q  <= rec_len - TMR_W'(1);
        left_q <= left_q - CNT_W'(1);
        xfer_q <= xfer_q + CNT_W'(1);
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - TMR_W'(1);
      end

      dev_ack <= (nxt == S_ACK) || (nxt == S_STB) || (nxt == S_REC);
      stb_q   <= (nxt == S_STB);
      dd_oe   <= dir_q && ((nxt == S_STB) || (nxt == S_REC));
    end
  end

  assign wr_ready   = dir_q && ((st == S_ACK) || (dec_pt && more));
  assign rd_capture = !dir_q && stb_end;
  assign word_end   = dec_pt;
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);
  assign done_words = xfer_q;
endmodule

// File: rtl/mdma_data.sv
module mdma_data #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_take,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_capture,
  input  logic [DW-1:0] dd_in,
  input  logic          rd_ready,
  output logic [DW-1:0] dd_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dd_out   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_take) dd_out <= wr_data;
      if (rd_capture) begin
        rd_data  <= dd_in;
        rd_valid <= 1'b1;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdma_host.sv
module mdma_host #(
  parameter int CLK_NS      = 5,
  parameter int CNT_W       = 16,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_write,
  input  logic [CNT_W-1:0] word_count,
  input  logic [1:0]       dma_mode,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] done_words,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  input  logic             dev_req,
  output logic             dev_ack,
  output logic             rd_strobe,
  output logic             wr_strobe,
  input  logic [DW-1:0]    dd_in,
  output logic [DW-1:0]    dd_out,
  output logic             dd_oe
);
  localparam int MAX_CYC = mdma_pkg::ns2cyc(mdma_pkg::cycle_ns(2'd0), CLK_NS);
  localparam int TMR_W   = $clog2(MAX_CYC + SYNC_STAGES + 2);

  logic             req_s, stb_q, dir_q, rd_capture, word_end, wr_take;
  logic [1:0]       mode_q;
  logic [TMR_W-1:0] stb_len, rec_len, win_len;

  mdma_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(dev_req), .q(req_s)
  );

  mdma_timing #(.CLK_NS(CLK_NS), .TMR_W(TMR_W), .SYNC_STAGES(SYNC_STAGES)) u_timing (
    .mode_q(mode_q), .stb_len(stb_len), .rec_len(rec_len), .win_len(win_len)
  );

  mdma_seq #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
    .word_count(word_count), .dma_mode(dma_mode),
    .stb_len(stb_len), .rec_len(rec_len), .win_len(win_len),
    .req_s(req_s), .wr_valid(wr_valid), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .mode_q(mode_q), .dir_q(dir_q), .dev_ack(dev_ack), .stb_q(stb_q),
    .dd_oe(dd_oe), .wr_ready(wr_ready), .rd_capture(rd_capture),
    .word_end(word_end), .busy(busy), .done(done), .done_words(done_words)
  );

  assign wr_take   = wr_ready && wr_valid;
  assign rd_strobe = stb_q && !dir_q;
  assign wr_strobe = stb_q && dir_q;

  mdma_data #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .wr_take(wr_take), .wr_data(wr_data),
    .rd_capture(rd_capture), .dd_in(dd_in), .rd_ready(rd_ready),
    .dd_out(dd_out), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/mdma_host_chk.sv
module mdma_host_chk #(
  parameter int CLK_NS = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] dma_mode,
  input logic       busy,
  input logic       done,
  input logic       dev_ack,
  input logic       rd_strobe,
  input logic       wr_strobe,
  input logic       dd_oe,
  input logic       wr_ready,
  input logic       req_s
);
  import mdma_pkg::*;

  logic        stb, seen;
  logic [1:0]  mode_cap;
  logic [15:0] hi_cnt, gap_cnt, exp_hi, exp_per;

  assign stb     = rd_strobe || wr_strobe;
  assign exp_hi  = 16'(ns2cyc(strobe_ns(mode_cap), CLK_NS));
  assign exp_per = 16'(ns2cyc(cycle_ns(mode_cap), CLK_NS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_cap <= 2'd0;
      hi_cnt   <= '0;
      gap_cnt  <= '0;
      seen     <= 1'b0;
    end else begin
      if (start && !busy) mode_cap <= dma_mode;
      hi_cnt  <= stb ? hi_cnt + 16'd1 : 16'd0;
      gap_cnt <= (stb && !seen) || (stb && hi_cnt == '0) ? 16'd1 : gap_cnt + 16'd1;
      if (!dev_ack) seen <= 1'b0;
      else if (stb) seen <= 1'b1;
    end
  end

  // R2
  stb_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> dev_ack);
  // R2
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_ack) |-> $past(req_s));
  // R5
  oe_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> dev_ack);
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb) |-> hi_cnt == exp_hi);
  // R4
  strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stb) && seen) |-> gap_cnt == exp_per);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dev_ack && !wr_ready));
endmodule

bind mdma_host mdma_host_chk #(.CLK_NS(CLK_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dma_mode(dma_mode), .busy(busy),
  .done(done), .dev_ack(dev_ack), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
  .dd_oe(dd_oe), .wr_ready(wr_ready), .req_s(req_s)
);

// File: tb/mdma_host_test.sv
`timescale 1ns/1ps
module mdma_host_test;
  logic        clk = 1'b0;
  logic        rst_n, start, dir_write, wr_valid, rd_ready, dev_req;
  logic [15:0] word_count, wr_data, dd_in;
  logic [1:0]  dma_mode;
  logic        busy, done, wr_ready, rd_valid, dev_ack, rd_strobe, wr_strobe, dd_oe;
  logic [15:0] done_words, rd_data, dd_out;

  always #2.5 clk = ~clk;

  mdma_host #(.CLK_NS(5)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
    .word_count(word_count), .dma_mode(dma_mode), .busy(busy), .done(done),
    .done_words(done_words), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .dev_req(dev_req), .dev_ack(dev_ack),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .dd_in(dd_in),
    .dd_out(dd_out), .dd_oe(dd_oe)
  );

  int total = 0, bad = 0, cur_mode = 2, ack_rises = 0;
  logic [15:0] wr_src[$], wr_exp[$], dev_rd[$], rd_exp[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle counts at 5 ns from the requirement tables
  function automatic int want_hi(input int m);
    if (m == 0) return 96;
    if (m == 1) return 48;
    return 24;
  endfunction
  function automatic int want_per(input int m);
    return 2 * want_hi(m);
  endfunction

  // host write stream source: pops after the edge that took the word
  initial begin
    bit take;
    wr_valid = 1'b0;
    wr_data  = '0;
    forever begin
      @(negedge clk); #1;
      take = wr_valid && wr_ready;
      @(posedge clk); #1;
      if (take) void'(wr_src.pop_front());
      wr_valid = (wr_src.size() > 0);
      wr_data  = wr_valid ? wr_src[0] : 16'h0;
    end
  end

  // drive model: a new read word on each read strobe rise
  initial dd_in = 16'h0;
  always @(posedge rd_strobe) dd_in = (dev_rd.size() > 0) ? dev_rd.pop_front() : 16'hBAD0;

  // monitor / scoreboard
  initial begin
    bit stb, p_stb = 0, p_ack = 0, seen = 0;
    int hi = 0, gap = 0;
    logic [15:0] e;
    forever begin
      @(negedge clk); #1;
      stb = rd_strobe | wr_strobe;
      gap++;
      if (dev_ack && !p_ack) ack_rises++;
      if (stb && !p_stb) begin
        chk(p_ack, "R2", "ack high cycle before strobe", p_ack, 1);
        if (seen) chk(gap == want_per(cur_mode), "R4", "strobe period", gap, want_per(cur_mode));
        gap = 0;
        seen = 1;
        if (wr_strobe) begin
          chk(dd_oe, "R5", "dd_oe during write strobe", dd_oe, 1);
          if (wr_exp.size() > 0) begin
            e = wr_exp.pop_front();
            chk(dd_out == e, "R5", "write word", dd_out, e);
          end else chk(0, "R5", "unexpected write strobe", dd_out, -1);
        end
      end
      if (stb) hi++;
      if (!stb && p_stb) begin
        chk(hi == want_hi(cur_mode), "R3", "strobe width", hi, want_hi(cur_mode));
        hi = 0;
      end
      if (!dev_ack) seen = 0;
      if (rd_valid && rd_ready) begin
        if (rd_exp.size() > 0) begin
          e = rd_exp.pop_front();
          chk(rd_data == e, "R6", "read word", rd_data, e);
        end else chk(0, "R6", "unexpected read word", rd_data, -1);
      end
      p_stb = stb;
      p_ack = dev_ack;
    end
  end

  task automatic run(input bit wr, input int cnt, input int m,
                     input int exp_words, input string req);
    cur_mode = (m == 3) ? 2 : m;
    @(negedge clk);
    start = 1'b1; dir_write = wr; word_count = 16'(cnt); dma_mode = 2'(m);
    @(negedge clk);
    start = 1'b0;
    #1;
    while (!done) begin @(negedge clk); #1; end
    chk(done_words == 16'(exp_words), req, "done_words", done_words, exp_words);
    @(negedge clk); #1;
    chk(!done, "R7", "done is a single pulse", done, 0);
  endtask

  task automatic push_wr(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_src.push_back(16'(base + i * 7));
      wr_exp.push_back(16'(base + i * 7));
    end
  endtask

  task automatic push_rd(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      dev_rd.push_back(16'(base ^ (i * 16'h1111)));
      rd_exp.push_back(16'(base ^ (i * 16'h1111)));
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    int r0;
    rst_n = 1'b0; start = 1'b0; dir_write = 1'b0; word_count = '0;
    dma_mode = 2'd2; rd_ready = 1'b1; dev_req = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    // R1: idle after reset
    chk(!dev_ack && !rd_strobe && !wr_strobe && !dd_oe, "R1", "bus outputs low",
        {dev_ack, rd_strobe, wr_strobe, dd_oe}, 0);
    chk(!busy && !done && !rd_valid && !wr_ready, "R1", "host outputs low",
        {busy, done, rd_valid, wr_ready}, 0);
    @(negedge clk); rst_n = 1'b1; dev_req = 1'b1;

    // R7 R5: full write burst, mode 2
    push_wr(4, 16'h1200);
    run(1, 4, 2, 4, "R7");
    chk(wr_exp.size() == 0, "R5", "all write words on bus", wr_exp.size(), 0);

    // R6 R7: read burst, mode 1
    push_rd(3, 16'hA5C3);
    run(0, 3, 1, 3, "R7");
    repeat (3) @(negedge clk);
    chk(rd_exp.size() == 0, "R6", "all read words delivered", rd_exp.size(), 0);

    // R3 R4: mode 0 write timing
    push_wr(2, 16'h0300);
    run(1, 2, 0, 2, "R7");

    // R10: mode 3 runs with mode 2 timing (monitor checks widths)
    push_rd(2, 16'h3C3C);
    run(0, 2, 3, 2, "R10");

    // R8: request dropped after second write strobe
    push_wr(6, 16'h0800);
    fork
      run(1, 6, 2, 2, "R8");
      begin
        repeat (2) @(posedge wr_strobe);
        @(negedge clk); dev_req = 1'b0;
      end
    join
    chk(wr_src.size() == 4, "R8", "words left in source", wr_src.size(), 4);
    wr_src.delete(); wr_exp.delete();
    repeat (3) @(negedge clk);

    // R2: armed but no request -> no acknowledge
    push_rd(1, 16'h7E7E);
    @(negedge clk);
    start = 1'b1; dir_write = 1'b0; word_count = 16'd1; dma_mode = 2'd2; cur_mode = 2;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    chk(busy && !dev_ack, "R2", "armed without request", {busy, dev_ack}, 2);
    dev_req = 1'b1;
    #1;
    while (!done) begin @(negedge clk); #1; end
    chk(done_words == 16'd1, "R2", "burst after request", done_words, 1);
    repeat (3) @(negedge clk);

    // R9: write stream runs dry
    push_wr(3, 16'h4400);
    run(1, 5, 2, 3, "R9");

    // R9: read word not taken stops the burst
    rd_ready = 1'b0;
    push_rd(1, 16'hC001);
    run(0, 4, 2, 1, "R9");
    #1;
    chk(rd_valid && rd_data == 16'hC001, "R9", "held read word", rd_data, 16'hC001);
    @(negedge clk); rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_exp.size() == 0, "R9", "held word drained", rd_exp.size(), 0);

    // R11: start during burst is ignored
    push_wr(2, 16'h5500);
    fork
      run(1, 2, 2, 2, "R11");
      begin
        repeat (30) @(negedge clk);
        start = 1'b1; dir_write = 1'b0; word_count = 16'd7;
        @(negedge clk); start = 1'b0;
      end
    join
    repeat (10) @(negedge clk);
    #1;
    chk(!busy && !dev_ack, "R11", "no second burst", {busy, dev_ack}, 0);

    // R12: zero count
    r0 = ack_rises;
    run(0, 0, 1, 0, "R12");
    repeat (5) @(negedge clk);
    chk(ack_rises == r0, "R12", "no acknowledge for zero count", ack_rises - r0, 0);

    finish_up();
  end
endmodule